// File: doc/BRIEF.md
# Break and Sync Auto-Baud Detector

This block listens to an asynchronous serial receive line, sampled by a fast reference clock, and learns the line's bit rate on its own. A transmitter announces a new rate by first pulling the line low for a long stretch (a break), releasing it for a short high gap (the delimiter), and then sending one ordinary start/stop framed byte with value 0x55. Sent least significant bit first, that byte produces a falling edge every two bit times. The detector times those edges in reference-clock cycles, checks that they are evenly spaced, and publishes a bit-period divisor that a receiver or transmitter datapath can load.

Break recognition adapts to the rate. Until a first divisor has been learned, a low stretch counts as a break when it lasts at least a programmable number of reference clocks. Once a divisor exists, the threshold becomes eleven bit times at that divisor. A low stretch longer than a programmable limit is reported as a break timeout and is not treated as a break. The same limit bounds the time the sync byte may take. A delimiter shorter than its programmable minimum, badly spaced sync edges, or a sync byte that takes too long are all reported as sync errors, and the previous divisor is kept.

Top module: `autobaud_det`

## Requirements
- R1: After reset, `divisor` is 0 and `break_flag`, `sync_done`, `sync_err` and `brk_timeout` are all 0.
- R2: A low stretch of L reference clocks (measured after the input synchronizer) is a break when L is at least the threshold: `brk_min` while no sync has ever completed, and 11 times `divisor` afterwards. A break raises `break_flag`, which stays high until the sync attempt that follows ends in success or error.
- R3: A low stretch shorter than the threshold raises no flag and leaves `divisor` unchanged.
- R4: A low stretch longer than `brk_max` clocks sets `brk_timeout` and is not a break. `brk_timeout` stays set until the next recognised break.
- R5: After a break, the high delimiter must last at least `delim_min` clocks before the next falling edge; a shorter delimiter sets `sync_err` and no sync completes.
- R6: The sync span S is the number of clocks from the sync start-bit falling edge to the fourth falling edge after it. On a valid sync, `divisor` becomes floor(S/8) and `sync_done` pulses high for exactly one cycle; `divisor` changes at no other time.
- R7: With e_k the clocks from the start edge to the k-th later falling edge (k = 1..4, e_4 = S), a sync is valid only if 16·|4·e_k − k·S| ≤ S for every k and floor(S/8) is non-zero; otherwise `sync_err` is set and `divisor` is kept.
- R8: `sync_err` stays set until the next recognised break clears it; `sync_done` never pulses while `sync_err` is high.
- R9: While `en` is low the detector ignores the line, holds `break_flag`, `sync_done`, `sync_err` and `brk_timeout` at 0, and keeps `divisor`.
- R10: If the fourth sync falling edge has not arrived within `brk_max` clocks of the start edge, `sync_err` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detector enable |
| rxd | input | 1 | Serial receive line, idle high |
| brk_min | input | CNT_W | Break threshold in clocks before any divisor is learned |
| brk_max | input | CNT_W | Longest allowed low stretch and longest allowed sync span |
| delim_min | input | CNT_W | Shortest allowed delimiter high time |
| divisor | output | CNT_W-3 | Learned bit period in reference clocks |
| break_flag | output | 1 | Break recognised, sync attempt in progress |
| sync_done | output | 1 | One-cycle strobe: new divisor loaded |
| sync_err | output | 1 | Delimiter, spacing or sync-duration error |
| brk_timeout | output | 1 | Low stretch exceeded `brk_max` |

## Verification
The assertions watch every cycle for the properties that need no knowledge of the stimulus: the done strobe lasts one cycle, the divisor moves only with that strobe and is then non-zero, a strobe follows only an edge-spacing check that passed, success and error never coexist, a timeout never counts as a break, and disabling clears every flag. Whether a given low stretch counts as a break, which threshold applies before and after learning, the exact divisor including truncation of an uneven span, and the rejection of a skewed sync byte, a short delimiter or an overlong sync depend on the waveform driven, so only the bench's scenarios can show them.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_GAP,
    ST_MEAS,
    ST_DRAIN
  } abd_state_e;

  // Break threshold: programmed floor before learning, 11 bit times after.
  function automatic logic [31:0] brk_limit(input logic have_div,
                                            input logic [31:0] div,
                                            input logic [31:0] floor_lim);
    return have_div ? (div * 32'd11) : floor_lim;
  endfunction

  // Divisor from an eight-bit-time span.
  function automatic logic [31:0] span_to_div(input logic [31:0] span);
    return span >> 3;
  endfunction

  // Falling edge k (nominally at 2k bit times) must sit within S/64
  // of k*S/4, i.e. one eighth of a bit period.
  function automatic logic edge_fits(input logic [31:0] ek,
                                     input logic [2:0]  k,
                                     input logic [31:0] span);
    logic [47:0] a, b, d;
    a = {14'd0, ek, 2'b00};
    b = {16'd0, span} * {45'd0, k};
    d = (a >= b) ? (a - b) : (b - a);
    return {d[43:0], 4'b0000} <= {16'd0, span};
  endfunction

endpackage

// File: rtl/abd_line_sync.sv
module abd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      line_q <= 1'b1;
    end else begin
      sh     <= {sh[STAGES-2:0], rxd};
      line_q <= sh[STAGES-1];
    end
  end

  assign line = sh[STAGES-1];
  assign fall = line_q & ~line;
endmodule

// File: rtl/abd_span_timer.sv
module abd_span_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (restart)       count <= W'(1);
    else if (count != '1)   count <= count + W'(1);
  end
endmodule

// File: rtl/abd_edge_judge.sv
module abd_edge_judge import abd_pkg::*; #(
  parameter int W     = 20,
  parameter int FALLS = 4,
  localparam int SLOT_W = $clog2(FALLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [SLOT_W-1:0] slot,
  input  logic [W-1:0]      stamp,
  output logic              fit
);
  logic [FALLS-2:0] ok;

  for (genvar g = 0; g < FALLS - 1; g++) begin : g_slot
    logic [W-1:0] stamp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  stamp_q <= '0;
      else if (capture && slot == SLOT_W'(g))      stamp_q <= stamp;
    end
    assign ok[g] = edge_fits(32'(stamp_q), 3'(g + 1), 32'(stamp));
  end

  // The last edge is the span itself; it only needs a non-zero divisor.
  assign fit = (&ok) && (span_to_div(32'(stamp)) != 32'd0);
endmodule

// File: rtl/autobaud_det.sv
module autobaud_det import abd_pkg::*; #(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2,
  localparam int DIV_W      = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rxd,
  input  logic [CNT_W-1:0] brk_min,
  input  logic [CNT_W-1:0] brk_max,
  input  logic [CNT_W-1:0] delim_min,
  output logic [DIV_W-1:0] divisor,
  output logic             break_flag,
  output logic             sync_done,
  output logic             sync_err,
  output logic             brk_timeout
);
  localparam int FALLS  = 4;
  localparam int SLOT_W = $clog2(FALLS);

  abd_state_e        st;
  logic              line, fall;
  logic [CNT_W-1:0]  timer;
  logic              restart;
  logic [SLOT_W-1:0] idx;
  logic              have_div;
  logic [31:0]       brk_thr;

  // Named events, shared with the checker.
  logic low_end, brk_hit, low_over;
  logic gap_end, gap_short;
  logic meas_fall, last_fall, meas_over;
  logic judge_fit, sync_good, sync_bad;

  abd_line_sync #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line), .fall(fall)
  );

  abd_span_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .count(timer)
  );

  abd_edge_judge #(.W(CNT_W), .FALLS(FALLS)) u_judge (
    .clk(clk), .rst_n(rst_n), .capture(meas_fall && !last_fall),
    .slot(idx), .stamp(timer), .fit(judge_fit)
  );

  assign brk_thr   = brk_limit(have_div, 32'(divisor), 32'(brk_min));
  assign low_end   = (st == ST_LOW) && line;
  assign brk_hit   = low_end && (32'(timer) >= brk_thr);
  assign low_over  = (st == ST_LOW) && !line && (timer >= brk_max);
  assign gap_end   = (st == ST_GAP) && !line;
  assign gap_short = gap_end && (timer < delim_min);
  assign meas_fall = (st == ST_MEAS) && fall;
  assign last_fall = meas_fall && (idx == SLOT_W'(FALLS - 1));
  assign meas_over = (st == ST_MEAS) && !last_fall && (timer >= brk_max);
  assign sync_good = last_fall && judge_fit;
  assign sync_bad  = gap_short || meas_over || (last_fall && !judge_fit);

  assign restart = ((st == ST_IDLE) && !line) || low_end || gap_end;

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else if (!en) begin
      st  <= ST_DRAIN;
      idx <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (!line) st <= ST_LOW;
        ST_LOW: begin
          if (low_over)     st <= ST_DRAIN;
          else if (brk_hit) st <= ST_GAP;
          else if (low_end) st <= ST_IDLE;
        end
        ST_GAP: begin
          idx <= '0;
          if (gap_short)    st <= ST_DRAIN;
          else if (gap_end) st <= ST_MEAS;
        end
        ST_MEAS: begin
          if (last_fall || meas_over) st <= ST_DRAIN;
          else if (meas_fall)         idx <= idx + SLOT_W'(1);
        end
        ST_DRAIN: if (line) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // Divisor and reporting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor     <= '0;
      have_div    <= 1'b0;
      break_flag  <= 1'b0;
      sync_done   <= 1'b0;
      sync_err    <= 1'b0;
      brk_timeout <= 1'b0;
    end else if (!en) begin
      break_flag  <= 1'b0;
      sync_done   <= 1'b0;
      sync_err    <= 1'b0;
      brk_timeout <= 1'b0;
    end else begin
      sync_done <= sync_good;
      if (sync_good) begin
        divisor  <= DIV_W'(span_to_div(32'(timer)));
        have_div <= 1'b1;
      end
      if (brk_hit)                     break_flag <= 1'b1;
      else if (sync_good || sync_bad)  break_flag <= 1'b0;
      if (brk_hit)       sync_err <= 1'b0;
      else if (sync_bad) sync_err <= 1'b1;
      if (brk_hit)       brk_timeout <= 1'b0;
      else if (low_over) brk_timeout <= 1'b1;
    end
  end
endmodule

// File: rtl/autobaud_det_chk.sv
module autobaud_det_chk #(
  parameter int DIV_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [DIV_W-1:0] divisor,
  input logic             break_flag,
  input logic             sync_done,
  input logic             sync_err,
  input logic             brk_timeout,
  input logic             brk_hit,
  input logic             low_over,
  input logic             last_fall,
  input logic             judge_fit
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> !sync_done);

  a_r6_div_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divisor) |-> sync_done);

  a_r7_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> divisor != '0);

  a_r7_done_after_fit: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> $past(last_fall && judge_fit));

  a_r8_done_not_err: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> !sync_err);

  a_r2_break_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en && brk_hit) |=> (break_flag && !sync_err && !brk_timeout));

  a_r4_timeout_not_break: assert property (@(posedge clk) disable iff (!rst_n)
    (en && low_over) |=> (brk_timeout && !break_flag));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!break_flag && !sync_done && !sync_err && !brk_timeout));
endmodule

bind autobaud_det autobaud_det_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .divisor(divisor),
  .break_flag(break_flag), .sync_done(sync_done), .sync_err(sync_err),
  .brk_timeout(brk_timeout), .brk_hit(brk_hit), .low_over(low_over),
  .last_fall(last_fall), .judge_fit(judge_fit)
);

// File: tb/autobaud_det_bench.sv
module autobaud_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 20;
  localparam int DIV_W = CNT_W - 3;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, rxd = 1'b1;
  logic [CNT_W-1:0] brk_min = 20'd200, brk_max = 20'd5000, delim_min = 20'd32;
  logic [DIV_W-1:0] divisor;
  logic break_flag, sync_done, sync_err, brk_timeout;

  int checks = 0, errors = 0, cycles = 0;
  int done_cnt = 0, bf_cnt = 0;
  logic bf_prev = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  autobaud_det #(.CNT_W(CNT_W)) u_autobaud_det (
    .clk(clk), .rst_n(rst_n), .en(en), .rxd(rxd), .brk_min(brk_min),
    .brk_max(brk_max), .delim_min(delim_min), .divisor(divisor),
    .break_flag(break_flag), .sync_done(sync_done), .sync_err(sync_err),
    .brk_timeout(brk_timeout)
  );

  // Observers sample on the inactive edge.
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (sync_done) done_cnt <= done_cnt + 1;
    if (break_flag && !bf_prev) bf_cnt <= bf_cnt + 1;
    bf_prev <= break_flag;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    @(negedge clk);
    rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  // 0x55 frame, LSB first; bit 'xb' (0 = start) gets 'extra' clocks.
  task automatic send_sync(input int t, input int xb, input int extra);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : 1'((8'h55 >> (i - 1)) & 1);
      hold(v, t + ((i == xb) ? extra : 0));
    end
    hold(1'b1, 100);
  endtask

  task automatic preamble(input int low, input int high);
    hold(1'b0, low);
    hold(1'b1, high);
  endtask

  task automatic t_reset;
    check("R1 divisor", int'(divisor), 0);
    check("R1 break_flag", int'(break_flag), 0);
    check("R1 sync_done", int'(sync_done), 0);
    check("R1 sync_err", int'(sync_err), 0);
    check("R1 brk_timeout", int'(brk_timeout), 0);
  endtask

  task automatic t_short_low;
    int b0 = bf_cnt;
    preamble(150, 300);
    check("R3 short low no break", bf_cnt - b0, 0);
    check("R3 divisor kept", int'(divisor), 0);
  endtask

  task automatic t_sync(input string tag, input int low, input int high,
                        input int t, input int xb, input int extra,
                        input int exp_div, input int exp_done, input int exp_bf,
                        input int exp_err);
    int d0 = done_cnt, b0 = bf_cnt;
    preamble(low, high);
    send_sync(t, xb, extra);
    check({tag, " done count"}, done_cnt - d0, exp_done);
    check({tag, " break count"}, bf_cnt - b0, exp_bf);
    check({tag, " divisor"}, int'(divisor), exp_div);
    check({tag, " sync_err"}, int'(sync_err), exp_err);
    check({tag, " break_flag idle"}, int'(break_flag), 0);
  endtask

  task automatic t_timeout;
    int b0 = bf_cnt;
    preamble(6000, 300);
    check("R4 timeout set", int'(brk_timeout), 1);
    check("R4 timeout not break", bf_cnt - b0, 0);
  endtask

  task automatic t_meas_timeout;
    int d0 = done_cnt;
    preamble(1200, 64);
    hold(1'b0, 6000);
    hold(1'b1, 300);
    check("R10 slow sync error", int'(sync_err), 1);
    check("R10 no done", done_cnt - d0, 0);
    check("R10 divisor kept", int'(divisor), 37);
  endtask

  task automatic t_disabled;
    int d0 = done_cnt, b0 = bf_cnt;
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 err cleared", int'(sync_err), 0);
    preamble(1200, 64);
    send_sync(50, 0, 0);
    check("R9 no done", done_cnt - d0, 0);
    check("R9 no break", bf_cnt - b0, 0);
    check("R9 divisor kept", int'(divisor), 37);
    @(negedge clk) en = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    en    = 1'b1;
    repeat (5) @(negedge clk);
    t_short_low();
    // R6: first learning, 704 >= brk_min
    t_sync("R6 first rate", 704, 64, 64, 0, 0, 64, 1, 1, 0);
    // R2: threshold is now 11*64 = 704; 700 is not a break
    t_sync("R2 learned threshold", 700, 200, 64, 0, 0, 64, 0, 0, 0);
    t_timeout();
    // R2 boundary 704 == 11*64 is a break; R4 timeout cleared
    t_sync("R2 boundary break", 704, 64, 40, 0, 0, 40, 1, 1, 0);
    check("R4 timeout cleared", int'(brk_timeout), 0);
    // R5: delimiter 10 < 32
    t_sync("R5 short delimiter", 800, 10, 40, 0, 0, 40, 0, 1, 1);
    // R7: d0 stretched by 20 at T=64
    t_sync("R7 skewed edge", 800, 64, 64, 1, 20, 40, 0, 1, 1);
    // R8: error cleared by next break; R6 new rate
    t_sync("R8 recovery", 1200, 50, 100, 0, 0, 100, 1, 1, 0);
    // R6: span 299 -> floor 37, within tolerance
    t_sync("R6 truncation", 1200, 64, 37, 7, 3, 37, 1, 1, 0);
    t_meas_timeout();
    t_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule